// File: doc/BRIEF.md
# Serial Peripheral Master with Sticky Chip Selects

This block is a single-master serial peripheral bus controller. On each transfer it shifts one byte out on MOSI, most significant bit first, and captures one byte from MISO at the same time. The serial clock comes from a power-of-two divider of the system clock. The divider spans divide-by-2 to divide-by-128, which gives 16 MHz down to 250 kHz from a 32 MHz system clock. Clock polarity and clock phase are set independently, so all four bus modes are available.

There are up to five active-low chip selects. Software that uses N selects wires them as outputs 0 to N-1, and a select-count input rejects any index beyond that range. A select can be released at the end of every transfer. It can also be held low across a run of back-to-back transfers, which keeps a device such as a serial memory enabled through a long burst. The host side is a plain register-style interface. It has a start strobe, transmit and receive bytes, busy, done and error flags, a divider code, mode bits, a select index and a hold control.

Top module: `spi_hold_master`

## Requirements
- R1: After reset all chip selects are high and busy, done and error are low. While idle, SCLK equals the clock-polarity input.
- R2: The divider code d gives an SCLK half period of 2^d system clocks, for d from 0 to 6. Code 7 behaves like code 6. One bit period is two half periods.
- R3: A transfer makes exactly 16 SCLK edges. The first edge moves SCLK away from the idle level set by polarity, and SCLK is back at the idle level when done rises.
- R4: With phase 0 (modes 0 and 2), MOSI carries the MSB before the first edge and advances on every trailing edge. MISO is sampled on every leading edge.
- R5: With phase 1 (modes 1 and 3), MOSI advances on leading edges and MISO is sampled on every trailing edge.
- R6: Data moves MSB first. Busy is high from the accepted start until the last edge. Done is then a one-cycle pulse, with the received byte valid on the receive port in the same cycle.
- R7: If hold is low when a transfer starts, its select goes high in the cycle that done rises.
- R8: If hold is high when a transfer starts, its select stays low after done and through further transfers to the same index. It goes high within two cycles of hold going low while idle.
- R9: If a start names a different index while another select is held, every select stays high for at least one bit period before the new select goes low.
- R10: A start whose index is at or above the select count (the count is clipped to 5) raises error for one cycle. It produces no busy, no select and no SCLK edge.
- R11: A start while busy is ignored. The running transfer keeps its data and select, and no second transfer follows.
- R12: At most one select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Transfer request strobe |
| tx_data_i | input | 8 | Byte to send |
| sel_idx_i | input | 3 | Target select index |
| sel_count_i | input | 3 | Number of selects in use |
| hold_i | input | 1 | Keep select low after transfer |
| cpol_i | input | 1 | Clock polarity (idle level) |
| cpha_i | input | 1 | Clock phase |
| div_i | input | 3 | Divider code, half period 2^code clocks |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle rejected-index pulse |
| rx_data_o | output | 8 | Received byte |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| ssel_n_o | output | 5 | Active-low chip selects |

## Verification
Transfers are run in all four modes with different byte pairs against a bus-level slave model. Each mode samples and launches on its own edges, so a swapped sampling edge corrupts the received byte in only some modes. Each mode is paired with a different divider code, including the clipped code 7, and the measured spacing of the edges separates a wrong divider from a wrong edge count. Held-select sequences check three cases: repeated transfers to the same index, a change of index, and release on hold going low. These show whether the select logic tells a continued burst apart from a switch. Rejected indices and starts issued mid-transfer check that neither causes any bus activity.

// File: rtl/spi_hold_pkg.sv
package spi_hold_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_GAP   = 2'd1,
      ST_SETUP = 2'd2,
      ST_XFER  = 2'd3
   } spi_st_e;
endpackage

// File: rtl/spi_hold_rate.sv
module spi_hold_rate #(
   parameter int DIV_W   = 3,
   parameter int DIV_MAX = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CW = DIV_MAX;

   if (DIV_MAX < 1) begin : g_bad_div
      $error("spi_hold_rate: DIV_MAX must be at least 1");
   end

   logic [CW-1:0]    cnt, lim;
   logic [DIV_W-1:0] div_eff;

   // Codes above DIV_MAX are clipped; limit is a run of ones of length div_eff.
   always_comb begin
      div_eff = (int'(div) > DIV_MAX) ? DIV_W'(DIV_MAX) : div;
      for (int i = 0; i < CW; i++) lim[i] = (i < int'(div_eff));
   end

   assign tick = run && (cnt == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (!run || tick) cnt <= '0;
      else                   cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_hold_engine.sv
module spi_hold_engine #(
   parameter int DATA_W = 8,
   parameter int EW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] tx,
   input  logic              cpha,
   input  logic              step,
   input  logic [EW-1:0]     edge_idx,
   input  logic              miso,
   output logic              mosi,
   output logic [DATA_W-1:0] rx_now
);
   if (DATA_W < 2) begin : g_bad_w
      $error("spi_hold_engine: DATA_W must be at least 2");
   end

   logic [DATA_W-1:0] txs, rxs;
   logic lead, samp, shft;

   // Even edge numbers leave the idle level, odd ones return to it.
   assign lead = ~edge_idx[0];

   if (1) begin : g_phase
      always_comb begin
         if (cpha) begin
            samp = step && !lead;
            shft = step && lead && (edge_idx != '0);
         end else begin
            samp = step && lead;
            shft = step && !lead;
         end
      end
   end

   assign mosi   = txs[DATA_W-1];
   assign rx_now = samp ? {rxs[DATA_W-2:0], miso} : rxs;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txs <= '0;
         rxs <= '0;
      end else if (load) begin
         txs <= tx;
         rxs <= '0;
      end else begin
         if (shft) txs <= {txs[DATA_W-2:0], 1'b0};
         if (samp) rxs <= {rxs[DATA_W-2:0], miso};
      end
   end

   // R4/R5: launch and capture never fall on the same edge
   a_r4_launch_capture_split: assert property (@(posedge clk) disable iff (!rst_n)
      !(samp && shft));
endmodule

// File: rtl/spi_hold_seldrv.sv
module spi_hold_seldrv #(
   parameter int NUM_SEL = 5,
   parameter int SW      = 3
) (
   input  logic               sel_on,
   input  logic [SW-1:0]      sel_idx,
   output logic [NUM_SEL-1:0] ssel_n
);
   for (genvar g = 0; g < NUM_SEL; g++) begin : g_sel
      assign ssel_n[g] = !(sel_on && (sel_idx == SW'(g)));
   end
endmodule

// File: rtl/spi_hold_master.sv
module spi_hold_master #(
   parameter int DATA_W  = 8,
   parameter int NUM_SEL = 5,
   parameter int DIV_W   = 3,
   parameter int DIV_MAX = 6,
   parameter int SW      = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
   parameter int CNTW    = $clog2(NUM_SEL + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [DATA_W-1:0]  tx_data_i,
   input  logic [SW-1:0]      sel_idx_i,
   input  logic [CNTW-1:0]    sel_count_i,
   input  logic               hold_i,
   input  logic               cpol_i,
   input  logic               cpha_i,
   input  logic [DIV_W-1:0]   div_i,
   output logic               busy_o,
   output logic               done_o,
   output logic               err_o,
   output logic [DATA_W-1:0]  rx_data_o,
   output logic               sclk_o,
   output logic               mosi_o,
   input  logic               miso_i,
   output logic [NUM_SEL-1:0] ssel_n_o
);
   import spi_hold_pkg::*;

   localparam int EW        = $clog2(2 * DATA_W);
   localparam int XW        = (SW > CNTW) ? SW : CNTW;
   localparam int LAST_EDGE = 2 * DATA_W - 1;

   if (NUM_SEL < 1 || NUM_SEL > (1 << SW)) begin : g_bad_sel
      $error("spi_hold_master: NUM_SEL does not fit the select index width");
   end

   spi_st_e          st;
   logic             cpol_q, cpha_q, hold_q, ph, sel_on, tick, load, step, idx_ok;
   logic [DIV_W-1:0] div_q;
   logic [SW-1:0]    sel_q;
   logic [EW-1:0]    ecnt;
   logic [CNTW-1:0]  cnt_eff;
   logic [DATA_W-1:0] rx_now;

   assign cnt_eff = (int'(sel_count_i) > NUM_SEL) ? CNTW'(NUM_SEL) : sel_count_i;
   assign idx_ok  = XW'(sel_idx_i) < XW'(cnt_eff);
   assign load    = (st == ST_IDLE) && start_i && idx_ok;
   assign step    = (st == ST_XFER) && tick;
   assign sclk_o  = busy_o ? (cpol_q ^ ph) : cpol_i;

   spi_hold_rate #(.DIV_W(DIV_W), .DIV_MAX(DIV_MAX)) u_rate (
      .clk(clk), .rst_n(rst_n), .run(st != ST_IDLE), .div(div_q), .tick(tick));

   spi_hold_engine #(.DATA_W(DATA_W), .EW(EW)) u_eng (
      .clk(clk), .rst_n(rst_n), .load(load), .tx(tx_data_i), .cpha(cpha_q),
      .step(step), .edge_idx(ecnt), .miso(miso_i), .mosi(mosi_o), .rx_now(rx_now));

   spi_hold_seldrv #(.NUM_SEL(NUM_SEL), .SW(SW)) u_sel (
      .sel_on(sel_on), .sel_idx(sel_q), .ssel_n(ssel_n_o));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;   busy_o <= 1'b0; done_o <= 1'b0; err_o <= 1'b0;
         rx_data_o <= '0; cpol_q <= 1'b0; cpha_q <= 1'b0; hold_q <= 1'b0;
         div_q <= '0;     ph <= 1'b0;     ecnt <= '0;     sel_on <= 1'b0;
         sel_q <= '0;
      end else begin
         done_o <= 1'b0;
         err_o  <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start_i && !idx_ok) begin
                  err_o <= 1'b1;
               end else if (start_i) begin
                  cpol_q <= cpol_i; cpha_q <= cpha_i; div_q <= div_i; hold_q <= hold_i;
                  busy_o <= 1'b1;   ph <= 1'b0;       ecnt <= '0;     sel_q <= sel_idx_i;
                  if (sel_on && (sel_q != sel_idx_i)) begin
                     sel_on <= 1'b0;
                     st     <= ST_GAP;
                  end else begin
                     sel_on <= 1'b1;
                     st     <= ST_SETUP;
                  end
               end else if (sel_on && !hold_i) begin
                  sel_on <= 1'b0;
               end
            end
            ST_GAP: if (tick) begin
               if (ecnt == EW'(1)) begin
                  ecnt   <= '0;
                  sel_on <= 1'b1;
                  st     <= ST_SETUP;
               end else begin
                  ecnt <= ecnt + 1'b1;
               end
            end
            ST_SETUP: if (tick) st <= ST_XFER;
            ST_XFER: if (tick) begin
               ph <= ~ph;
               if (ecnt == EW'(LAST_EDGE)) begin
                  st        <= ST_IDLE;
                  busy_o    <= 1'b0;
                  done_o    <= 1'b1;
                  rx_data_o <= rx_now;
                  if (!hold_q) sel_on <= 1'b0;
               end else begin
                  ecnt <= ecnt + 1'b1;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   // R12: never more than one select low
   a_r12_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~ssel_n_o));
   // R6: done is a single-cycle pulse that ends a busy period
   a_r6_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);
   a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> ($past(busy_o) && !busy_o));
   // R10: a rejected request leaves the bus idle
   a_r10_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (!busy_o && (&ssel_n_o)));
   // R9: all selects high during the switch gap
   a_r9_gap_all_high: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_GAP) |-> (&ssel_n_o));
   // R11: select and mode stay put while bits are moving
   a_r11_xfer_steady: assert property (@(posedge clk) disable iff (!rst_n)
      ((st == ST_XFER) && ($past(st) == ST_XFER)) |-> ($stable(ssel_n_o) && $stable(cpha_q)));
   // R3: clock is at idle level when done rises
   a_r3_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (ph == 1'b0));
endmodule

// File: tb/sim_spi_hold_master.sv
module sim_spi_hold_master;
   logic       clk = 1'b0, rst_n = 1'b0;
   logic       start_i = 1'b0, hold_i = 1'b0, cpol_i = 1'b0, cpha_i = 1'b0;
   logic [7:0] tx_data_i = '0;
   logic [2:0] sel_idx_i = '0, sel_count_i = 3'd5, div_i = '0;
   logic       busy_o, done_o, err_o, sclk_o, mosi_o, miso_i;
   logic [7:0] rx_data_o;
   logic [4:0] ssel_n_o;

   int n_checks = 0, n_fail = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   spi_hold_master u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_data_i(tx_data_i),
      .sel_idx_i(sel_idx_i), .sel_count_i(sel_count_i), .hold_i(hold_i),
      .cpol_i(cpol_i), .cpha_i(cpha_i), .div_i(div_i), .busy_o(busy_o),
      .done_o(done_o), .err_o(err_o), .rx_data_o(rx_data_o), .sclk_o(sclk_o),
      .mosi_o(mosi_o), .miso_i(miso_i), .ssel_n_o(ssel_n_o));

   // Bus-level slave model
   logic       m_on = 0, m_cpol = 0, m_cpha = 0, m_first = 1, m_multi = 0;
   logic [7:0] s_tx = '0, s_rx = '0;
   int         m_edges = 0, m_hp_bad = 0;
   time        m_last = 0, m_hp_exp = 8, t_rise0 = 0, t_fall2 = 0;
   int         m_rise1 = 0;

   assign miso_i = s_tx[7];

   always @(sclk_o) if (m_on) begin
      if (m_edges > 0 && ($time - m_last) != m_hp_exp) m_hp_bad++;
      m_last = $time;
      m_edges++;
      if ((sclk_o != m_cpol) == !m_cpha) s_rx = {s_rx[6:0], mosi_o};
      else if (m_cpha && m_first) m_first = 0;
      else s_tx = {s_tx[6:0], 1'b0};
   end

   always @(posedge ssel_n_o[1]) m_rise1++;
   always @(posedge ssel_n_o[0]) t_rise0 = $time;
   always @(negedge ssel_n_o[2]) t_fall2 = $time;
   always @(negedge clk) if (rst_n && $countones(~ssel_n_o) > 1) m_multi = 1;

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic prep(input logic [1:0] mode, input logic [2:0] dv, input int hp_clks,
                       input logic [7:0] stx);
      m_on = 0;
      @(negedge clk);
      cpol_i = mode[1]; cpha_i = mode[0]; div_i = dv;
      m_cpol = mode[1]; m_cpha = mode[0];
      s_tx = stx; s_rx = '0; m_first = 1; m_edges = 0; m_hp_bad = 0;
      m_hp_exp = 8 * hp_clks;
      @(negedge clk);
      m_on = 1;
   endtask

   task automatic pulse_start(input logic [2:0] idx, input logic hold, input logic [7:0] tx);
      start_i = 1; sel_idx_i = idx; hold_i = hold; tx_data_i = tx;
      @(negedge clk);
      start_i = 0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done_o && n < 20000) begin @(negedge clk); n++; end
   endtask

   task automatic t_reset();
      check(ssel_n_o == 5'h1F, "R1 selects", ssel_n_o, 5'h1F);
      check({busy_o, done_o, err_o} == 3'b000, "R1 flags", {busy_o, done_o, err_o}, 0);
      check(sclk_o == cpol_i, "R1 idle sclk", sclk_o, cpol_i);
   endtask

   task automatic t_mode(input logic [1:0] mode, input logic [2:0] dv, input int hp,
                         input logic [7:0] tx, input logic [7:0] stx, input logic [2:0] idx);
      prep(mode, dv, hp, stx);
      pulse_start(idx, 0, tx);
      check(busy_o == 1, "R6 busy after start", busy_o, 1);
      check(ssel_n_o[idx] == 0, "R6 select low", ssel_n_o, idx);
      if (!mode[0]) check(mosi_o == tx[7], "R4 msb before first edge", mosi_o, tx[7]);
      wait_done();
      check(rx_data_o == stx, mode[0] ? "R5 rx byte" : "R4 rx byte", rx_data_o, stx);
      check(s_rx == tx, mode[0] ? "R5 slave got" : "R4 slave got", s_rx, tx);
      check(m_edges == 16, "R3 edge count", m_edges, 16);
      check(m_hp_bad == 0, "R2 half period", m_hp_bad, 0);
      check(sclk_o == mode[1], "R3 idle after done", sclk_o, mode[1]);
      check(ssel_n_o == 5'h1F, "R7 auto release", ssel_n_o, 5'h1F);
      check(busy_o == 0, "R6 busy low at done", busy_o, 0);
      @(negedge clk);
      check(done_o == 0, "R6 done one cycle", done_o, 0);
      m_on = 0;
   endtask

   task automatic t_hold();
      prep(2'd0, 3'd1, 2, 8'h81);
      pulse_start(3'd1, 1, 8'h3C);
      wait_done();
      check(rx_data_o == 8'h81, "R8 first rx", rx_data_o, 8'h81);
      check(ssel_n_o == 5'b11101, "R8 held after done", ssel_n_o, 5'b11101);
      m_rise1 = 0;
      repeat (10) @(negedge clk);
      check(ssel_n_o == 5'b11101, "R8 still held", ssel_n_o, 5'b11101);
      prep(2'd0, 3'd1, 2, 8'h7E);
      pulse_start(3'd1, 1, 8'hC3);
      wait_done();
      check(rx_data_o == 8'h7E && s_rx == 8'hC3, "R8 second rx", rx_data_o, 8'h7E);
      check(m_rise1 == 0, "R8 no release between", m_rise1, 0);
      hold_i = 0;
      repeat (2) @(negedge clk);
      check(ssel_n_o == 5'h1F, "R8 release on hold low", ssel_n_o, 5'h1F);
   endtask

   task automatic t_switch();
      m_multi = 0;
      prep(2'd3, 3'd2, 4, 8'h96);
      pulse_start(3'd0, 1, 8'h11);
      wait_done();
      check(ssel_n_o == 5'b11110, "R8 select 0 held", ssel_n_o, 5'b11110);
      prep(2'd3, 3'd2, 4, 8'h2D);
      pulse_start(3'd2, 1, 8'hE7);
      wait_done();
      check((t_fall2 - t_rise0) >= 64, "R9 gap one bit", 32'(t_fall2 - t_rise0), 64);
      check(rx_data_o == 8'h2D && s_rx == 8'hE7, "R9 switched transfer", rx_data_o, 8'h2D);
      check(ssel_n_o == 5'b11011, "R9 new select held", ssel_n_o, 5'b11011);
      check(m_multi == 0, "R12 single select", m_multi, 0);
      hold_i = 0;
      repeat (2) @(negedge clk);
   endtask

   task automatic t_error();
      prep(2'd0, 3'd0, 1, 8'h00);
      sel_count_i = 3'd3;
      pulse_start(3'd3, 0, 8'hAA);
      check(err_o == 1, "R10 err pulse", err_o, 1);
      check(busy_o == 0 && ssel_n_o == 5'h1F, "R10 no activity", {busy_o, ssel_n_o}, 6'h1F);
      @(negedge clk);
      check(err_o == 0, "R10 err one cycle", err_o, 0);
      sel_count_i = 3'd7;
      pulse_start(3'd5, 0, 8'hAA);
      check(err_o == 1, "R10 count clipped", err_o, 1);
      repeat (40) @(negedge clk);
      check(m_edges == 0 && busy_o == 0, "R10 no edges", m_edges, 0);
      sel_count_i = 3'd3;
      t_mode(2'd0, 3'd0, 1, 8'h42, 8'h24, 3'd2);
      sel_count_i = 3'd5;
   endtask

   task automatic t_busy_ignore();
      int dones = 0;
      prep(2'd0, 3'd2, 4, 8'hB4);
      pulse_start(3'd0, 0, 8'h5A);
      repeat (10) @(negedge clk);
      pulse_start(3'd4, 0, 8'hFF);
      while (!done_o) begin @(negedge clk); end
      dones++;
      check(s_rx == 8'h5A && rx_data_o == 8'hB4, "R11 data kept", s_rx, 8'h5A);
      repeat (200) begin @(negedge clk); if (done_o) dones++; end
      check(dones == 1 && m_edges == 16, "R11 no second transfer", m_edges, 16);
      check(busy_o == 0 && ssel_n_o == 5'h1F, "R11 bus idle", ssel_n_o, 5'h1F);
      m_on = 0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_mode(2'd0, 3'd0, 1,  8'hA5, 8'h3C, 3'd0);
      t_mode(2'd1, 3'd1, 2,  8'h0F, 8'hF1, 3'd1);
      t_mode(2'd2, 3'd3, 8,  8'h6B, 8'h92, 3'd3);
      t_mode(2'd3, 3'd2, 4,  8'hC1, 8'h1E, 3'd4);
      t_mode(2'd1, 3'd7, 64, 8'h80, 8'h01, 3'd2);
      t_hold();
      t_switch();
      t_error();
      t_busy_ignore();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end
endmodule